// File: doc/BRIEF.md
# Per-Cylinder Knock-Adaptive Ignition Angle Adjuster

This block holds one signed ignition-advance trim for each of four cylinders. Each ignition event comes in as a strobe with a cylinder index, a knock flag from an external knock detector, and a base angle. The base angle is worked out upstream from engine load (an 8-bit airflow value) and engine speed. On that strobe the block adds the trim for the indexed cylinder to the base angle and presents the sum, registered, on the next clock.

After producing the angle, the block adapts that cylinder's trim. An event with no knock raises the trim by a small step, which moves the spark toward the knock limit. An event with knock lowers the trim by a larger step, which retards the spark. Trims clamp at parameter limits and never wrap. Each cylinder adapts only from its own events.

Top module: `knock_trim_adjuster`

## Requirements
- R1: While rst_ni is low, all four trims are 0, angle_o is 0 and angle_vld_o is 0.
- R2: angle_vld_o is high in exactly the clock after a clock in which evt_vld_i was high, and low at every other time.
- R3: On a valid event, angle_o = base_angle_i + trim[cyl_i]. The trim used is the value held before this event's update. The result is signed and saturates at 8 bits, in the range -128 to 127.
- R4: On a valid event with knock_i=0, trim[cyl_i] increases by INC_STEP (default 1). The trim never rises above TRIM_MAX (default 15).
- R5: On a valid event with knock_i=1, trim[cyl_i] decreases by DEC_STEP (default 4). The trim never falls below TRIM_MIN (default -16).
- R6: An event changes only the trim of the cylinder named by cyl_i, which is a 2-bit index from 0 to 3. The trims of the other cylinders stay unchanged.
- R7: When evt_vld_i is low, no trim changes, whatever the values on knock_i and cyl_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_vld_i | input | 1 | Ignition event strobe |
| cyl_i | input | 2 | Cylinder index |
| knock_i | input | 1 | Knock seen on this event |
| base_angle_i | input | 8 | Base advance, signed |
| angle_o | output | 8 | Corrected advance, signed, registered |
| angle_vld_o | output | 1 | angle_o is valid |

## Verification
A trim that is wrong inside the block is not visible straight away. It shows up in angle_o only on the next event for the same cylinder, one clock after that strobe. The bench therefore follows every update with a later event on the same cylinder, and it uses a base angle of 0 there so that the output equals the trim itself. The limit tests drive long runs of clean events, or of knock events, against one cylinder. The cross-talk test updates one cylinder and then reads the other three.

// File: rtl/knock_trim_pkg.sv
package knock_trim_pkg;
  localparam int unsigned ANGLE_W = 8;
  localparam int unsigned TRIM_W  = 6;
  localparam int unsigned N_CYL   = 4;
  localparam int unsigned CYL_W   = $clog2(N_CYL);
  typedef logic signed [TRIM_W-1:0]  trim_t;
  typedef logic signed [ANGLE_W-1:0] angle_t;
endpackage

// File: rtl/trim_cell.sv
module trim_cell
  import knock_trim_pkg::*;
#(
  parameter int INC_STEP = 1,
  parameter int DEC_STEP = 4,
  parameter int TRIM_MAX = 15,
  parameter int TRIM_MIN = -16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_i,
  input  logic  knock_i,
  output trim_t trim_o
);
  localparam int CALC_W = TRIM_W + 2;
  logic signed [CALC_W-1:0] nxt;

  always_comb begin
    nxt = CALC_W'(trim_o);
    if (knock_i) nxt = nxt - CALC_W'(DEC_STEP);
    else         nxt = nxt + CALC_W'(INC_STEP);
    if (nxt > CALC_W'(TRIM_MAX)) nxt = CALC_W'(TRIM_MAX);
    if (nxt < CALC_W'(TRIM_MIN)) nxt = CALC_W'(TRIM_MIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    trim_o <= '0;
    else if (upd_i) trim_o <= trim_t'(nxt);
  end
endmodule

// File: rtl/angle_sum.sv
module angle_sum
  import knock_trim_pkg::*;
(
  input  angle_t base_i,
  input  trim_t  trim_i,
  output angle_t sum_o
);
  localparam int SW = ANGLE_W + 1;
  localparam int HI = (1 << (ANGLE_W - 1)) - 1;
  localparam int LO = -(1 << (ANGLE_W - 1));
  logic signed [SW-1:0] s;

  always_comb begin
    s = SW'(base_i) + SW'(trim_i);
    if      (s > SW'(HI)) sum_o = angle_t'(HI);
    else if (s < SW'(LO)) sum_o = angle_t'(LO);
    else                  sum_o = angle_t'(s);
  end
endmodule

// File: rtl/knock_trim_adjuster.sv
module knock_trim_adjuster
  import knock_trim_pkg::*;
#(
  parameter int INC_STEP = 1,
  parameter int DEC_STEP = 4,
  parameter int TRIM_MAX = 15,
  parameter int TRIM_MIN = -16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_vld_i,
  input  logic [1:0] cyl_i,
  input  logic       knock_i,
  input  logic [7:0] base_angle_i,
  output logic [7:0] angle_o,
  output logic       angle_vld_o
);
  trim_t  trim_q [N_CYL];
  trim_t  trim_sel;
  angle_t sum;

  for (genvar g = 0; g < N_CYL; g++) begin : g_cyl
    trim_cell #(
      .INC_STEP(INC_STEP), .DEC_STEP(DEC_STEP),
      .TRIM_MAX(TRIM_MAX), .TRIM_MIN(TRIM_MIN)
    ) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .upd_i   (evt_vld_i && (cyl_i == CYL_W'(g))),
      .knock_i (knock_i),
      .trim_o  (trim_q[g])
    );
  end

  assign trim_sel = trim_q[cyl_i];

  angle_sum u_sum (
    .base_i (angle_t'(base_angle_i)),
    .trim_i (trim_sel),
    .sum_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      angle_o     <= '0;
      angle_vld_o <= 1'b0;
    end else begin
      angle_vld_o <= evt_vld_i;
      if (evt_vld_i) angle_o <= sum;
    end
  end
endmodule

// File: rtl/knock_trim_checker.sv
module knock_trim_checker
  import knock_trim_pkg::*;
#(
  parameter int TRIM_MAX = 15,
  parameter int TRIM_MIN = -16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_vld_i,
  input logic [1:0] cyl_i,
  input logic       angle_vld_o,
  input logic [7:0] angle_o,
  input trim_t      t0,
  input trim_t      t1,
  input trim_t      t2,
  input trim_t      t3
);
  // R2
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_vld_i |=> angle_vld_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_vld_i |=> !angle_vld_o);
  // R4 / R5
  a_r4_r5_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(t0) <= TRIM_MAX) && (int'(t0) >= TRIM_MIN) &&
    (int'(t3) <= TRIM_MAX) && (int'(t3) >= TRIM_MIN));
  // R7
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_vld_i |=> $stable(t0) && $stable(t1) && $stable(t2) && $stable(t3));
  a_r7_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_vld_i |=> $stable(angle_o));
  // R6
  a_r6_iso0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && cyl_i != 2'd0) |=> $stable(t0));
  a_r6_iso3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && cyl_i != 2'd3) |=> $stable(t3));
endmodule

bind knock_trim_adjuster knock_trim_checker #(.TRIM_MAX(TRIM_MAX), .TRIM_MIN(TRIM_MIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_vld_i(evt_vld_i), .cyl_i(cyl_i),
  .angle_vld_o(angle_vld_o), .angle_o(angle_o),
  .t0(trim_q[0]), .t1(trim_q[1]), .t2(trim_q[2]), .t3(trim_q[3])
);

// File: tb/tb_knock_trim_adjuster.sv
module tb_knock_trim_adjuster;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [1:0] cyl = '0;
  logic knk = 1'b0;
  logic [7:0] base = '0;
  logic [7:0] ang;
  logic avld;
  int errs = 0, chks = 0;
  int mtrim [4];

  always #2 clk = ~clk;

  knock_trim_adjuster dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_vld_i(vld), .cyl_i(cyl), .knock_i(knk),
    .base_angle_i(base), .angle_o(ang), .angle_vld_o(avld)
  );

  // {cyl, knock, base}
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'd10}, {2'd0, 1'b0, 8'd10}, {2'd1, 1'b1, 8'd20},
    {2'd1, 1'b0, 8'd20}, {2'd2, 1'b0, 8'hF0}, {2'd0, 1'b1, 8'd0},
    {2'd3, 1'b1, 8'd100}, {2'd3, 1'b1, 8'd100}, {2'd2, 1'b0, 8'd5},
    {2'd0, 1'b0, 8'd1}
  };

  task automatic chk(input string r, input int act, input int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic int sat8(input int v);
    return v > 127 ? 127 : (v < -128 ? -128 : v);
  endfunction

  // drive one event, check output one clock later
  task automatic evt(input int c, input bit k, input int b, input string r);
    int exp;
    exp = sat8(b + mtrim[c]);
    @(negedge clk);
    vld = 1; cyl = 2'(c); knk = k; base = 8'(b);
    @(negedge clk);
    vld = 0; knk = ~k; cyl = ~cyl;
    chk(r, int'(avld), 1);
    chk(r, int'($signed(ang)), exp);
    if (k) mtrim[c] = (mtrim[c] - 4 < -16) ? -16 : mtrim[c] - 4;
    else   mtrim[c] = (mtrim[c] + 1 > 15) ? 15 : mtrim[c] + 1;
  endtask

  initial begin
    #40000; errs++; $display("FAIL watchdog");
    $display("Result: errors=%0d of %0d checks", errs, chks); $finish;
  end

  initial begin
    foreach (mtrim[i]) mtrim[i] = 0;
    #5;
    chk("R1", int'(avld), 0); chk("R1", int'(ang), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R2", int'(avld), 0);
    for (int i = 0; i < NV; i++)
      evt(VEC[i][10:9], VEC[i][8], int'($signed(VEC[i][7:0])), "R3");
    @(negedge clk); chk("R2 idle", int'(avld), 0);
    // R4 upper saturation on cyl 1
    for (int i = 0; i < 25; i++) evt(1, 0, 0, "R4");
    evt(1, 0, 0, "R4 at max"); chk("R4 max", mtrim[1], 15);
    // R5 lower saturation on cyl 2
    for (int i = 0; i < 12; i++) evt(2, 1, 0, "R5");
    evt(2, 1, 0, "R5 at min"); chk("R5 min", mtrim[2], -16);
    // R3 output saturation
    evt(1, 0, 120, "R3 sat hi");
    evt(2, 1, -120, "R3 sat lo");
    // R6 isolation: read every cylinder back
    for (int c = 0; c < 4; c++) evt(c, 0, 0, "R6");
    // R7 idle toggling does nothing
    repeat (5) begin
      @(negedge clk); knk = ~knk; cyl = cyl + 1;
    end
    for (int c = 0; c < 4; c++) evt(c, 1, 0, "R7");
    // R1 reset mid-run clears trims
    @(negedge clk); rst_n = 0; #1;
    chk("R1 rst", int'(avld), 0); chk("R1 rst", int'(ang), 0);
    @(negedge clk); rst_n = 1;
    foreach (mtrim[i]) mtrim[i] = 0;
    for (int c = 0; c < 4; c++) evt(c, 0, 0, "R1 trims zero");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule